// File: doc/BRIEF.md
# Automatic conversion interval timer

This block paces an automatic sampling mode. It holds one control register. A small code field in that register picks how many conversion-time units pass between successive conversion starts. An outside source supplies a one-cycle strobe once per conversion-time unit. The block counts these strobes and, when the chosen interval has elapsed, raises a single-cycle start request for the converter. It then begins the next interval.

The interval is a power-of-two multiple of the conversion time, from 32 to 2048 units. One code value switches automatic pacing off. Two upper register bits control delay mechanisms that live elsewhere in the converter. This block only stores them and presents them as active-low enables. The register is written and read through a simple parallel port.

Top module: `acp_pacer`

## Requirements
- R1: After reset the register reads 0x00, `start_o` is 0, `auto_on_o` is 0 and both delay-enable outputs are 0.
- R2: While the interval code (register bits 2..0) is 000, `auto_on_o` is 0 and `start_o` never rises, whatever the strobe does.
- R3: For interval code c in 1..7, the interval is 16·2^c strobes (32, 64, 128, 256, 512, 1024 or 2048). The first start comes on the strobe that ends one full interval after the code was written, and starts then repeat every interval. `auto_on_o` is 1 for every nonzero code.
- R4: A write stores data bits 7, 6 and 2..0 and forces bits 5..3 to 0. `rd_data_o` shows the stored register from the cycle after the write, so writing 0xFF reads back 0xC7.
- R5: `samp_dly_n_o` equals register bit 7 and `trial_dly_n_o` equals register bit 6. A value of 0 means that delay is enabled.
- R6: Any write restarts the interval count from zero, even one that rewrites the same nonzero code. A write in the same cycle as the strobe that would end an interval suppresses that start.
- R7: `start_o` is high for exactly one cycle. It is high only in the cycle right after a clock edge at which `unit_tick_i` was sampled high.
- R8: Writing code 000 stops counting at once and discards the partial count, so no start is issued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Current register value |
| unit_tick_i | input | 1 | One-cycle strobe per conversion-time unit |
| start_o | output | 1 | One-cycle conversion-start request |
| auto_on_o | output | 1 | High while a nonzero interval code is held |
| samp_dly_n_o | output | 1 | Sampling-instant delay enable, active low |
| trial_dly_n_o | output | 1 | Bit-trial delay enable, active low |

## Verification
A wrong interval count shows at `start_o` as a start pulse that comes early or late, or that is missing. This becomes visible by the end of the first interval after a write, which is at most 2048 strobes. A decode fault shows the same way, because every code is timed against its own expected period. A restart that is lost, or a zero code that does not stop the counter, shows up as a stray pulse within one interval of the write. Register masking faults appear on `rd_data_o` and on the delay outputs one cycle after the write.

// File: rtl/acp_pkg.sv
package acp_pkg;
   localparam int REG_W_DEF   = 8;
   localparam int CODE_W_DEF  = 3;
   localparam int BASE_LG_DEF = 5;

   // counter width able to hold the largest interval minus one
   function automatic int span_width(input int base_lg, input int code_w);
      return base_lg + (1 << code_w) - 2;
   endfunction
endpackage

// File: rtl/acp_ctl_reg.sv
module acp_ctl_reg #(
   parameter int REG_W  = acp_pkg::REG_W_DEF,
   parameter int CODE_W = acp_pkg::CODE_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic [CODE_W-1:0] code,
   output logic              samp_n,
   output logic              trial_n,
   output logic              load
);
   localparam int PAD_W = REG_W - CODE_W - 2;

   logic [CODE_W-1:0] code_q;
   logic              samp_q, trial_q;

   generate
      if (PAD_W < 0) begin : g_bad_w
         $error("acp_ctl_reg: REG_W too small for code and delay bits");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= '0;
         samp_q  <= 1'b0;
         trial_q <= 1'b0;
      end else if (wr_en) begin
         code_q  <= wr_data[CODE_W-1:0];
         samp_q  <= wr_data[REG_W-1];
         trial_q <= wr_data[REG_W-2];
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {samp_q, trial_q, {PAD_W{1'b0}}, code_q};
      end else begin : g_nopad
         assign rd_data = {samp_q, trial_q, code_q};
      end
   endgenerate

   assign code    = code_q;
   assign samp_n  = samp_q;
   assign trial_n = trial_q;
   assign load    = wr_en;
endmodule

// File: rtl/acp_span_decode.sv
module acp_span_decode #(
   parameter int CODE_W  = acp_pkg::CODE_W_DEF,
   parameter int BASE_LG = acp_pkg::BASE_LG_DEF,
   parameter int CNT_W   = acp_pkg::span_width(BASE_LG, CODE_W)
) (
   input  logic [CODE_W-1:0] code,
   output logic              run,
   output logic [CNT_W-1:0]  last
);
   localparam int NCODE = 1 << CODE_W;

   logic [CNT_W-1:0] tbl [NCODE];

   generate
      if (BASE_LG < 1) begin : g_bad_base
         $error("acp_span_decode: BASE_LG must be at least 1");
      end
      if (CNT_W < BASE_LG + NCODE - 2) begin : g_bad_cnt
         $error("acp_span_decode: CNT_W cannot hold the longest interval");
      end
   endgenerate

   assign tbl[0] = '0;
   for (genvar g = 1; g < NCODE; g++) begin : g_span
      // terminal count: base shifted by (g-1), minus one
      assign tbl[g] = CNT_W'((64'd1 << (BASE_LG + g - 1)) - 64'd1);
   end

   assign run  = (code != '0);
   assign last = tbl[code];
endmodule

// File: rtl/acp_span_count.sv
module acp_span_count #(
   parameter int CNT_W    = 11,
   parameter bit FIRE_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] last,
   output logic             fire
);
   logic [CNT_W-1:0] cnt_q;
   logic             hit;

   assign hit = run && tick && !load && (cnt_q == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load || !run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= hit ? '0 : cnt_q + 1'b1;
      end
   end

   generate
      if (FIRE_REG) begin : g_fire_reg
         logic fire_q;
         always_ff @(posedge clk) begin
            if (!rst_n) fire_q <= 1'b0;
            else        fire_q <= hit;
         end
         assign fire = fire_q;
      end else begin : g_fire_comb
         assign fire = hit;
      end
   endgenerate
endmodule

// File: rtl/acp_pacer.sv
module acp_pacer #(
   parameter int REG_W    = acp_pkg::REG_W_DEF,
   parameter int CODE_W   = acp_pkg::CODE_W_DEF,
   parameter int BASE_LG  = acp_pkg::BASE_LG_DEF,
   parameter bit FIRE_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] rd_data_o,
   input  logic             unit_tick_i,
   output logic             start_o,
   output logic             auto_on_o,
   output logic             samp_dly_n_o,
   output logic             trial_dly_n_o
);
   localparam int CNT_W = acp_pkg::span_width(BASE_LG, CODE_W);

   logic [CODE_W-1:0] code;
   logic              load, run;
   logic [CNT_W-1:0]  last;

   acp_ctl_reg #(.REG_W(REG_W), .CODE_W(CODE_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_i),
      .wr_data (wr_data_i),
      .rd_data (rd_data_o),
      .code    (code),
      .samp_n  (samp_dly_n_o),
      .trial_n (trial_dly_n_o),
      .load    (load)
   );

   acp_span_decode #(.CODE_W(CODE_W), .BASE_LG(BASE_LG), .CNT_W(CNT_W)) u_dec (
      .code (code),
      .run  (run),
      .last (last)
   );

   acp_span_count #(.CNT_W(CNT_W), .FIRE_REG(FIRE_REG)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .run   (run),
      .tick  (unit_tick_i),
      .last  (last),
      .fire  (start_o)
   );

   assign auto_on_o = run;
endmodule

// File: rtl/acp_pacer_chk.sv
module acp_pacer_chk #(
   parameter int REG_W  = 8,
   parameter int CODE_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en_i,
   input logic [REG_W-1:0] wr_data_i,
   input logic [REG_W-1:0] rd_data_o,
   input logic             unit_tick_i,
   input logic             start_o,
   input logic             auto_on_o,
   input logic             samp_dly_n_o,
   input logic             trial_dly_n_o
);
   localparam int PAD_W = REG_W - CODE_W - 2;
   localparam logic [REG_W-1:0] KEEP =
      {2'b11, {PAD_W{1'b0}}, {CODE_W{1'b1}}};

   // R7
   start_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> $past(unit_tick_i));

   // R7
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   // R2
   start_needs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_on_o |-> !start_o);

   // R6
   write_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en_i) |-> !start_o);

   // R4
   write_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en_i) |-> (rd_data_o == ($past(wr_data_i) & KEEP)));

   // R5
   delay_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_dly_n_o == rd_data_o[REG_W-1]) && (trial_dly_n_o == rd_data_o[REG_W-2]));
endmodule

bind acp_pacer acp_pacer_chk #(.REG_W(REG_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/acp_pacer_test.sv
module acp_pacer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [7:0] wr_data_i = 8'h00;
   logic [7:0] rd_data_o;
   logic       unit_tick_i = 1'b0;
   logic       start_o, auto_on_o, samp_dly_n_o, trial_dly_n_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference state
   logic [7:0] m_reg = 8'h00;
   int         m_cnt = 0;
   logic       m_start = 1'b0;

   always #2 clk = ~clk;

   acp_pacer uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en_i       (wr_en_i),
      .wr_data_i     (wr_data_i),
      .rd_data_o     (rd_data_o),
      .unit_tick_i   (unit_tick_i),
      .start_o       (start_o),
      .auto_on_o     (auto_on_o),
      .samp_dly_n_o  (samp_dly_n_o),
      .trial_dly_n_o (trial_dly_n_o)
   );

   function automatic int span_of(input logic [2:0] c);
      return (c == 3'd0) ? 0 : (16 << c);
   endfunction

   function automatic logic [7:0] masked(input logic [7:0] d);
      return d & 8'hC7;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, model the edge, compare at next negedge
   task automatic step(input logic we, input logic [7:0] wd, input logic tk);
      int sp;
      wr_en_i = we; wr_data_i = wd; unit_tick_i = tk;
      @(posedge clk);
      sp = span_of(m_reg[2:0]);
      m_start = 1'b0;
      if (we) begin
         m_reg = masked(wd);
         m_cnt = 0;
      end else if (sp != 0 && tk) begin
         if (m_cnt == sp - 1) begin
            m_cnt = 0;
            m_start = 1'b1;
         end else m_cnt++;
      end
      @(negedge clk);
      wr_en_i = 1'b0; unit_tick_i = 1'b0;
      check("R3/R7 start", {31'd0, start_o}, {31'd0, m_start});
      check("R4 readback", {24'd0, rd_data_o}, {24'd0, m_reg});
      check("R2/R3 auto_on", {31'd0, auto_on_o}, {31'd0, m_reg[2:0] != 3'd0});
      check("R5 delay bits", {30'd0, samp_dly_n_o, trial_dly_n_o}, {30'd0, m_reg[7], m_reg[6]});
   endtask

   // ticks every cycle; returns ticks up to and including the pulse
   task automatic ticks_to_pulse(output int n);
      n = 0;
      do begin
         step(1'b0, 8'h00, 1'b1);
         n++;
      end while (!start_o && n < 3000);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int n;
      int seed;
      logic [7:0] wd;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rd_data", {24'd0, rd_data_o}, 32'h0);
      check("R1 start", {31'd0, start_o}, 32'h0);
      check("R1 auto_on", {31'd0, auto_on_o}, 32'h0);
      check("R1 delays", {30'd0, samp_dly_n_o, trial_dly_n_o}, 32'h0);

      // R2 code 000 with ticks: no starts
      for (int i = 0; i < 100; i++) step(1'b0, 8'h00, 1'b1);

      // R4 / R5 masking and delay outputs
      step(1'b1, 8'hFF, 1'b0);
      check("R4 0xFF readback", {24'd0, rd_data_o}, 32'hC7);
      check("R5 both high", {30'd0, samp_dly_n_o, trial_dly_n_o}, 32'h3);
      step(1'b1, 8'h79, 1'b0);
      check("R5 bit6 only", {30'd0, samp_dly_n_o, trial_dly_n_o}, 32'h1);

      // R3 every code, first and second interval
      for (int c = 1; c < 8; c++) begin
         step(1'b1, 8'(c), 1'b0);
         ticks_to_pulse(n);
         check("R3 first interval", n, span_of(3'(c)));
         ticks_to_pulse(n);
         check("R3 repeat interval", n, span_of(3'(c)));
      end

      // R6 rewrite same code mid-interval restarts
      step(1'b1, 8'h01, 1'b0);
      for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 1'b1);
      step(1'b1, 8'h01, 1'b0);
      ticks_to_pulse(n);
      check("R6 restart", n, 32);
      // R6 write on the completing tick suppresses the pulse
      for (int i = 0; i < 31; i++) step(1'b0, 8'h00, 1'b1);
      step(1'b1, 8'h01, 1'b1);
      check("R6 suppressed", {31'd0, start_o}, 32'h0);
      ticks_to_pulse(n);
      check("R6 after suppress", n, 32);

      // R8 zero code stops on the completing tick
      step(1'b1, 8'h02, 1'b0);
      for (int i = 0; i < 63; i++) step(1'b0, 8'h00, 1'b1);
      step(1'b1, 8'h00, 1'b1);
      check("R8 no start", {31'd0, start_o}, 32'h0);
      check("R8 auto off", {31'd0, auto_on_o}, 32'h0);
      for (int i = 0; i < 200; i++) step(1'b0, 8'h00, 1'b1);
      // R8 partial count discarded
      step(1'b1, 8'h01, 1'b0);
      ticks_to_pulse(n);
      check("R8 fresh count", n, 32);

      // random phase: sparse ticks, occasional writes
      for (int i = 0; i < 30000; i++) begin
         logic we, tk;
         we = ($urandom % 400) == 0;
         tk = ($urandom % 3) != 0;
         wd = 8'($urandom);
         if (($urandom % 4) == 0) wd[2:0] = 3'd1;
         step(we, wd, tk);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule